// File: doc/BRIEF.md
# Serial Output-Control Slave for an Eight-Channel Switch

This block is the serial front end of an eight-channel low-side switch controller. A host selects it with an active-low chip select and clocks in 16-bit frames. Each frame is a command byte and then a channel byte. The block shifts out a 16-bit diagnostic word on the same frame. The diagnostic word is captured when chip select falls. When chip select rises, the channel byte is moved into an eight-bit output latch, but only if the command byte asks for it and the frame had exactly sixteen clocks. That rise also sends a one-cycle clear pulse to the diagnosis logic.

The serial pins are not used as clocks. Chip select, serial clock, serial data and the active-low kill input all pass through a synchronizer into a faster system clock, and edges are found in that domain. Incoming data is taken on falling serial-clock edges. Outgoing data moves on rising edges. Both directions send the most significant bit first. The serial output has a separate enable, which models the high-impedance state while the block is deselected.

Top module: `spi_outctl_slave`

## Requirements
- R1: The bit on `sdi` is taken at each falling `sclk` edge, most significant bit first. In a frame of exactly 16 bits whose first byte (frame bits 15..8) is 0xFF, the last byte (frame bits 7..0) is loaded into `chan_on` when `cs_n` rises. Frame bit 0 drives `chan_on[0]` (channel 1) and frame bit 7 drives `chan_on[7]` (channel 8). A 1 turns a channel on.
- R2: When `cs_n` falls, `diag_in` is captured and `sdo` shows `diag_in[15]`. After k falling `sclk` edges, for k from 1 to 15, the next rising edge makes `sdo` show `diag_in[15-k]`.
- R3: `sdo_oe` goes high after `cs_n` falls and goes low after `cs_n` rises. While `sdo_oe` is low, `sdo` is 0.
- R4: A 16-bit frame whose first byte is not 0xFF (0x00 or any other value) leaves `chan_on` unchanged.
- R5: A frame with any number of falling `sclk` edges other than 16 leaves `chan_on` unchanged.
- R6: Each rising edge of `cs_n` produces exactly one single-cycle pulse on `diag_clr`, whether or not the frame was applied.
- R7: While `cs_n` is high, activity on `sclk` and `sdi` changes neither `chan_on` nor `sdo_oe`.
- R8: While `kill_n` is low, `chan_on` is forced to all zeros and the receive state is cleared. A frame that is interrupted by `kill_n` is not applied.
- R9: While `rst` is high, on the next clock edge `chan_on` becomes 0 and `sdo_oe` and `diag_clr` become low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| kill_n | input | 1 | Asynchronous active-low kill: all channels off, receiver cleared |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial diagnostic data to the host |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| diag_in | input | 16 | Diagnostic status word, captured when chip select falls |
| chan_on | output | 8 | Latched channel-enable vector |
| diag_clr | output | 1 | One-cycle clear pulse to the diagnosis register when deselected |

## Verification
The assertions assume that every serial edge is seen in the system domain. This means each level of `sclk` and `cs_n` lasts at least a few system clocks. They also assume `sclk` is low whenever `cs_n` changes, and that `diag_in` does not change around the falling edge of chip select. The stimulus holds every serial phase for six system clocks. It parks `sclk` low before each chip-select transition and sets up the diagnostic word before each frame. Random frames vary the command byte, the channel byte, the diagnostic word and the bit count within those limits.

// File: rtl/spi_outctl_pkg.sv
package spi_outctl_pkg;

  // Index of each pin inside the synchronizer vector
  localparam int unsigned PIN_CSN   = 0;
  localparam int unsigned PIN_SCLK  = 1;
  localparam int unsigned PIN_SDI   = 2;
  localparam int unsigned PIN_KILLN = 3;
  localparam int unsigned PIN_N     = 4;

  // Idle level of each pin, so a reset synchronizer shows no spurious edge
  localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1001;

  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sck_rise;
    logic sck_fall;
  } spi_edges_t;

endpackage

// File: rtl/spi_outctl_sync.sv
module spi_outctl_sync #(
  parameter int unsigned          W       = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [W-1:0]         RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < int'(STAGES); k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < int'(STAGES); k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_outctl_shifter.sv
module spi_outctl_shifter #(
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned CNT_MAX = FRAME_W + 1,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               kill_i,
  input  logic               sel_i,
  input  spi_outctl_pkg::spi_edges_t edg_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] diag_i,
  output logic [FRAME_W-1:0] rx_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               tx_msb_o
);

  logic [FRAME_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tx_adv;

  // Outgoing data moves only after the first bit has been taken in
  assign tx_adv = edg_i.sck_rise && (cnt_q != '0) && (cnt_q < CNT_W'(FRAME_W));

  always_ff @(posedge clk) begin
    if (rst || kill_i) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
    end else if (edg_i.cs_fall) begin
      rx_q  <= '0;
      tx_q  <= diag_i;
      cnt_q <= '0;
    end else if (sel_i) begin
      if (edg_i.sck_fall) begin
        rx_q <= {rx_q[FRAME_W-2:0], sdi_i};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
      if (tx_adv) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign rx_o     = rx_q;
  assign cnt_o    = cnt_q;
  assign tx_msb_o = tx_q[FRAME_W-1];

  // R5: the bit counter saturates and never wraps back to a valid count
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(CNT_MAX));

  // R7: a deselected interface keeps its receive state
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!sel_i && !kill_i && !edg_i.cs_fall) |=> $stable(rx_q) && $stable(cnt_q));

endmodule

// File: rtl/spi_outctl_latch.sv
module spi_outctl_latch #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CH_N    = 8,
  localparam int unsigned CMD_W  = FRAME_W - CH_N,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               kill_i,
  input  logic               cs_rise_i,
  input  logic [FRAME_W-1:0] rx_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [CH_N-1:0]    chan_o
);

  logic [CH_N-1:0]  chan_q;
  logic [CMD_W-1:0] cmd;
  logic             apply;

  assign cmd   = rx_i[FRAME_W-1:CH_N];
  assign apply = cs_rise_i && (cnt_i == CNT_W'(FRAME_W)) && (&cmd);

  always_ff @(posedge clk) begin
    if (rst || kill_i)  chan_q <= '0;
    else if (apply)     chan_q <= rx_i[CH_N-1:0];
  end

  assign chan_o = chan_q;

  // R4: outside a deselect edge the latch cannot move
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!kill_i && !cs_rise_i) |=> $stable(chan_q));

  // R8: kill forces every channel off
  p_kill_off_r8: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> (chan_q == '0));

endmodule

// File: rtl/spi_outctl_slave.sv
module spi_outctl_slave #(
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned CH_N        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               kill_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdo_oe,
  input  logic [FRAME_W-1:0] diag_in,
  output logic [CH_N-1:0]    chan_on,
  output logic               diag_clr
);
  import spi_outctl_pkg::*;

  logic [PIN_N-1:0] pins_raw, pins_s;
  logic             cs_q, sck_q;
  spi_edges_t       edg;
  logic             kill, sel;
  logic [FRAME_W-1:0] rx;
  logic [CNT_W-1:0]   cnt;
  logic             tx_msb;
  logic             oe_q, clr_q;

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_CSN]   = cs_n;
    pins_raw[PIN_SCLK]  = sclk;
    pins_raw[PIN_SDI]   = sdi;
    pins_raw[PIN_KILLN] = kill_n;
  end

  spi_outctl_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pins_raw),
    .q_o (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= pins_s[PIN_CSN];
      sck_q <= pins_s[PIN_SCLK];
    end
  end

  assign edg.cs_fall  = cs_q && !pins_s[PIN_CSN];
  assign edg.cs_rise  = !cs_q && pins_s[PIN_CSN];
  assign edg.sck_rise = !sck_q && pins_s[PIN_SCLK];
  assign edg.sck_fall = sck_q && !pins_s[PIN_SCLK];
  assign kill         = !pins_s[PIN_KILLN];
  assign sel          = !pins_s[PIN_CSN];

  spi_outctl_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .kill_i   (kill),
    .sel_i    (sel),
    .edg_i    (edg),
    .sdi_i    (pins_s[PIN_SDI]),
    .diag_i   (diag_in),
    .rx_o     (rx),
    .cnt_o    (cnt),
    .tx_msb_o (tx_msb)
  );

  spi_outctl_latch #(.FRAME_W(FRAME_W), .CH_N(CH_N)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .kill_i    (kill),
    .cs_rise_i (edg.cs_rise),
    .rx_i      (rx),
    .cnt_i     (cnt),
    .chan_o    (chan_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      if (edg.cs_fall)      oe_q <= 1'b1;
      else if (edg.cs_rise) oe_q <= 1'b0;
      clr_q <= edg.cs_rise;
    end
  end

  assign sdo_oe   = oe_q;
  assign sdo      = oe_q & tx_msb;
  assign diag_clr = clr_q;

  // R3: selection edges steer the output enable
  p_oe_on_r3: assert property (@(posedge clk) disable iff (rst)
    edg.cs_fall |=> sdo_oe);
  p_oe_off_r3: assert property (@(posedge clk) disable iff (rst)
    edg.cs_rise |=> !sdo_oe);

  // R6: the clear output is a single-cycle pulse
  p_clr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    diag_clr |=> !diag_clr);

  // R9: reset leaves the outputs quiet
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!sdo_oe && !diag_clr && chan_on == '0));

endmodule

// File: tb/spi_outctl_slave_tb_top.sv
`timescale 1ns/1ps
module spi_outctl_slave_tb_top;

  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        kill_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe, diag_clr;
  logic [15:0] diag_in = '0;
  logic [7:0]  chan_on;

  int tests = 0;
  int fails = 0;
  int frames = 0;
  int clr_cnt = 0;
  logic [7:0] model = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_outctl_slave dut_i (
    .clk(clk), .rst(rst), .kill_n(kill_n), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .diag_in(diag_in),
    .chan_on(chan_on), .diag_clr(diag_clr)
  );

  always @(posedge clk) if (!rst && diag_clr) clr_cnt++;

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] next_model(logic [7:0] cur, logic [15:0] w, int nbits);
    if (nbits == 16 && w[15:8] == 8'hFF) return w[7:0];
    return cur;
  endfunction

  task automatic start_frame(logic [15:0] d);
    diag_in = d;
    wait_n(2);
    cs_n = 1'b0;
    wait_n(HP);
    chk("R3 oe on", sdo_oe, 1);
    chk("R2 first bit", sdo, d[15]);
  endtask

  task automatic clk_bit(bit b, bit chk_so, bit exp_so);
    sdi  = b;
    sclk = 1'b1;
    wait_n(HP);
    if (chk_so) chk("R2 so bit", sdo, exp_so);
    sclk = 1'b0;
    wait_n(HP);
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    wait_n(HP + 2);
    frames++;
    chk("R3 oe off", sdo_oe, 0);
    chk("R3 sdo quiet", sdo, 0);
    chk("R6 clear pulse count", clr_cnt, frames);
  endtask

  task automatic run_frame(logic [15:0] w, int nbits, logic [15:0] d);
    string tag;
    start_frame(d);
    for (int i = 0; i < nbits; i++)
      clk_bit(i < 16 ? w[15-i] : 1'($urandom % 2), i < 16, i < 16 ? d[15-i] : 1'b0);
    end_frame();
    model = next_model(model, w, nbits);
    if (nbits != 16)          tag = "R5 bit count";
    else if (w[15:8] != 8'hFF) tag = "R4 command";
    else                      tag = "R1 apply";
    chk(tag, chan_on, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    wait_n(10);
    // R9: state held by reset
    chk("R9 chan", chan_on, 0);
    chk("R9 oe", sdo_oe, 0);
    chk("R9 clr", diag_clr, 0);
    rst = 1'b0;
    wait_n(4);

    // R1: channel mapping, bit 0 drives channel 1
    run_frame(16'hFF01, 16, 16'hA5C3);
    chk("R1 channel1", chan_on[0], 1);
    run_frame(16'hFFA5, 16, 16'h3C96);
    // R4: discard commands
    run_frame(16'h003C, 16, 16'hFFFF);
    run_frame(16'h7F3C, 16, 16'h0001);
    run_frame(16'hFE00, 16, 16'h8000);
    // R5: short and long frames
    run_frame(16'hFF3C, 15, 16'h1234);
    run_frame(16'hFF3C, 17, 16'h4321);
    run_frame(16'hFF3C, 0, 16'h0F0F);

    // R7: activity while deselected is ignored
    for (int i = 0; i < 16; i++) begin
      sdi = 1'b1; sclk = 1'b1; wait_n(HP);
      chk("R7 oe idle", sdo_oe, 0);
      sclk = 1'b0; wait_n(HP);
    end
    chk("R7 chan idle", chan_on, model);

    // R8: kill while idle
    kill_n = 1'b0; wait_n(HP);
    chk("R8 kill off", chan_on, 0);
    kill_n = 1'b1; wait_n(HP);
    model = '0;
    run_frame(16'hFF5A, 16, 16'h6666);

    // R8: kill in the middle of a frame aborts it
    start_frame(16'h0000);
    for (int i = 0; i < 8; i++) clk_bit(1'b1, 1'b0, 1'b0);
    kill_n = 1'b0; wait_n(HP);
    chk("R8 kill mid", chan_on, 0);
    kill_n = 1'b1; wait_n(HP);
    for (int i = 0; i < 8; i++) clk_bit(1'b1, 1'b0, 1'b0);
    end_frame();
    model = '0;
    chk("R8 aborted frame", chan_on, 0);

    // Random frames
    for (int n = 0; n < 40; n++) begin
      logic [15:0] w, d;
      int nb, sel;
      d   = 16'($urandom);
      sel = int'($urandom % 4);
      w[7:0]  = 8'($urandom);
      w[15:8] = (sel < 2) ? 8'hFF : (sel == 2 ? 8'h00 : 8'($urandom));
      nb  = ($urandom % 5 == 0) ? int'(12 + $urandom % 9) : 16;
      run_frame(w, nb, d);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule